// File: doc/BRIEF.md
# Partial Reconfiguration Loader Register Block

This block is the software-facing register slave of a partial-reconfiguration loader. Software reaches it over a plain 64-bit register bus with an address, write data, a write strobe, a read strobe and read data. Through that bus it runs a reset request/acknowledge handshake, picks a 3-bit target region and opens a load session with a start bit. It then streams 32-bit configuration words into an internal queue, pacing itself on the free-entry count that the status register reports. It closes the session with a complete bit. The hardware clears start and complete by itself once every queued word has left.

Words leave the queue on a valid/ready stream, in the order they were written, towards whatever engine programs the fabric. That engine reports an operation failure, a CRC mismatch or an incompatible image as single-cycle pulses. Those pulses, together with locally detected protocol violations and queue overflows, set sticky error flags. Software clears the flags by writing ones to them. A 128-bit identifier, fixed by a parameter, lets software confirm that an image suits the hardware before it loads it.

Top module: `pr_engine_regs`

## Requirements
- R1: Reads are registered: a read strobe in one cycle puts the selected register on `bus_rdata` after the next rising edge, and the value is held until the next read. Byte offsets are: control 0x08, status 0x10, data 0x18, error 0x20, identifier upper half 0xA8 (ID[127:64]), identifier lower half 0xB0 (ID[63:0]). Any other offset, and the data register, read as zero.
- R2: Control bit 0 is the reset request. Control bit 4 is read-only and reads 1 one cycle after the request is seen set, and 0 one cycle after it is removed. While the request is held, the queue is emptied, start and complete read 0, and status bit 16 returns to 0 (idle).
- R3: Control bits 9:7 hold a region number that software can write and read back, and that drives `region_sel`.
- R4: Writing control with bit 12 set sets the start bit. Status bit 16 (busy) reads 1 exactly while start is set.
- R5: A data write while start is set and the queue is not full stores bits 31:0 of the written value as one word, and status bits 8:0 drop by one. Status bits 8:0 always give the number of free queue entries (`DEPTH` after reset).
- R6: Stored words appear on `out_word` in write order, with `out_valid` high. A word stays unchanged until it is taken on a cycle where `out_valid` and `out_ready` are both high, and each word taken returns one credit.
- R7: Control bit 13 (complete) can be set only while start is set. When start and complete are both set and the queue is empty, the hardware clears both. Writing 0 to bit 12 never clears start.
- R8: A data write while start is set and no credit is left sets error bit 4 and drops the word.
- R9: A data write while start is clear sets error bit 3 and drops the word.
- R10: A write to the error register clears exactly the bits that are 1 in the written value. A flag set in the same cycle as its clear stays set.
- R11: A one-cycle pulse on `ev_op_err`, `ev_crc_err` or `ev_bad_image` sets error bit 0, 1 or 2 respectively.
- R12: Status bits 22:20 show `ctl_status_in` and bits 27:24 show `host_status_in`. All other unlisted register bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 64 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 64 | Registered read data |
| out_valid | output | 1 | Queue head word is available |
| out_ready | input | 1 | Consumer accepts the head word |
| out_word | output | 32 | Queue head word |
| ev_op_err | input | 1 | Pulse: operation failure |
| ev_crc_err | input | 1 | Pulse: CRC mismatch |
| ev_bad_image | input | 1 | Pulse: incompatible image |
| ctl_status_in | input | 3 | Controller status shown in status bits 22:20 |
| host_status_in | input | 4 | Host status shown in status bits 27:24 |
| region_sel | output | 3 | Selected target region |

## Verification
The properties assume that the consumer may stall for any number of cycles, that the bus presents at most one access per cycle and never reads and writes in the same cycle, and that the error pulses may coincide with register writes. The stimulus keeps to these rules. It drives every bus access and every pulse for exactly one cycle, away from the clock edge. It holds `out_ready` low while it fills the queue, so that credit exhaustion and overflow are reached deliberately. It lowers `out_ready` again before it raises a reset request, so that the words it flushes are known exactly.

// File: rtl/pr_regs_pkg.sv
package pr_regs_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 64;
    localparam int WORD_W   = 32;
    localparam int CREDIT_W = 9;
    localparam int ERR_N    = 5;

    // byte offsets decoded by software
    localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_STAT = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_DATA = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_ERR  = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_IDH  = 8'hA8;
    localparam logic [ADDR_W-1:0] OFF_IDL  = 8'hB0;

    // control bit positions
    localparam int CB_RST_REQ = 0;
    localparam int CB_REG_LO  = 7;
    localparam int CB_START   = 12;
    localparam int CB_DONE    = 13;

    // error flag positions
    localparam int EB_OP    = 0;
    localparam int EB_CRC   = 1;
    localparam int EB_IMG   = 2;
    localparam int EB_PROTO = 3;
    localparam int EB_OVF   = 4;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_CTRL, SEL_STAT, SEL_DATA, SEL_ERR, SEL_IDH, SEL_IDL
    } reg_sel_e;

    typedef struct packed {
        logic [49:0] rsv3;
        logic        done;
        logic        start;
        logic [1:0]  rsv2;
        logic [2:0]  region;
        logic [1:0]  rsv1;
        logic        ack;
        logic [2:0]  rsv0;
        logic        rst_req;
    } ctrl_view_t;

    typedef struct packed {
        logic [35:0]         rsv3;
        logic [3:0]          host;
        logic                rsv2;
        logic [2:0]          ctl;
        logic [2:0]          rsv1;
        logic                busy;
        logic [6:0]          rsv0;
        logic [CREDIT_W-1:0] credits;
    } stat_view_t;

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
        case (a)
            OFF_CTRL: return SEL_CTRL;
            OFF_STAT: return SEL_STAT;
            OFF_DATA: return SEL_DATA;
            OFF_ERR:  return SEL_ERR;
            OFF_IDH:  return SEL_IDH;
            OFF_IDL:  return SEL_IDL;
            default:  return SEL_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(
        input logic rst_req, input logic ack, input logic [2:0] region,
        input logic start, input logic done);
        ctrl_view_t v;
        v         = '0;
        v.rst_req = rst_req;
        v.ack     = ack;
        v.region  = region;
        v.start   = start;
        v.done    = done;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] pack_stat(
        input logic [CREDIT_W-1:0] credits, input logic busy,
        input logic [2:0] ctl, input logic [3:0] host);
        stat_view_t v;
        v         = '0;
        v.credits = credits;
        v.busy    = busy;
        v.ctl     = ctl;
        v.host    = host;
        return v;
    endfunction

endpackage

// File: rtl/pr_word_queue.sv
module pr_word_queue #(
    parameter int DEPTH = 256,
    parameter int W     = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    output logic          full,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [W-1:0]  out_word,
    output logic [LW-1:0] level
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          push_ok, pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full      = (level == LW'(DEPTH));
    assign out_valid = (level != '0);
    assign out_word  = mem[rp];
    assign push_ok   = push && !full && !flush;
    assign pop       = out_valid && out_ready && !flush;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (push_ok) wp <= step(wp);
            if (pop)     rp <= step(rp);
            case ({push_ok, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= din;
    end

endmodule

// File: rtl/pr_sticky_errors.sv
module pr_sticky_errors #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic         clr_en,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flags
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags[i] <= 1'b0;
            else if (set_vec[i])
                flags[i] <= 1'b1;
            else if (clr_en && clr_mask[i])
                flags[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/pr_seq_ctrl.sv
module pr_seq_ctrl (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_ctrl,
    input  logic       wr_rst_req,
    input  logic [2:0] wr_region,
    input  logic       wr_start,
    input  logic       wr_done,
    input  logic       queue_empty,
    output logic       rst_req,
    output logic       rst_ack,
    output logic [2:0] region,
    output logic       start,
    output logic       done
);

    logic finish;

    // session ends once complete is flagged and every word has left
    assign finish = start && done && queue_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req <= 1'b0;
            rst_ack <= 1'b0;
            region  <= '0;
            start   <= 1'b0;
            done    <= 1'b0;
        end else begin
            rst_ack <= rst_req;
            if (wr_ctrl) begin
                rst_req <= wr_rst_req;
                region  <= wr_region;
            end
            if (rst_req || finish)
                start <= 1'b0;
            else if (wr_ctrl && wr_start)
                start <= 1'b1;
            if (rst_req || finish)
                done <= 1'b0;
            else if (wr_ctrl && wr_done && start)
                done <= 1'b1;
        end
    end

endmodule

// File: rtl/pr_engine_regs.sv
module pr_engine_regs
    import pr_regs_pkg::*;
#(
    parameter int           DEPTH  = 256,
    parameter logic [127:0] IFC_ID = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
    localparam int          LW     = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_we,
    input  logic                bus_re,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [WORD_W-1:0]   out_word,
    input  logic                ev_op_err,
    input  logic                ev_crc_err,
    input  logic                ev_bad_image,
    input  logic [2:0]          ctl_status_in,
    input  logic [3:0]          host_status_in,
    output logic [2:0]          region_sel
);

    reg_sel_e            sel;
    logic                wr_ctrl, wr_data, wr_err;
    logic                rst_req, rst_ack, start, done;
    logic                full;
    logic [LW-1:0]       level;
    logic [CREDIT_W-1:0] credits;
    logic [ERR_N-1:0]    err_flags, err_set;
    logic                proto_hit, ovf_hit;
    logic                unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:WORD_W];

    assign sel     = decode_offset(bus_addr);
    assign wr_ctrl = bus_we && (sel == SEL_CTRL);
    assign wr_data = bus_we && (sel == SEL_DATA);
    assign wr_err  = bus_we && (sel == SEL_ERR);

    assign proto_hit = wr_data && !start;
    assign ovf_hit   = wr_data && start && full;
    assign credits   = CREDIT_W'(DEPTH) - CREDIT_W'(level);

    always_comb begin
        err_set           = '0;
        err_set[EB_OP]    = ev_op_err;
        err_set[EB_CRC]   = ev_crc_err;
        err_set[EB_IMG]   = ev_bad_image;
        err_set[EB_PROTO] = proto_hit;
        err_set[EB_OVF]   = ovf_hit;
    end

    pr_seq_ctrl u_seq (
        .clk         (clk),
        .rst         (rst),
        .wr_ctrl     (wr_ctrl),
        .wr_rst_req  (bus_wdata[CB_RST_REQ]),
        .wr_region   (bus_wdata[CB_REG_LO +: 3]),
        .wr_start    (bus_wdata[CB_START]),
        .wr_done     (bus_wdata[CB_DONE]),
        .queue_empty (!out_valid),
        .rst_req     (rst_req),
        .rst_ack     (rst_ack),
        .region      (region_sel),
        .start       (start),
        .done        (done)
    );

    pr_word_queue #(.DEPTH(DEPTH), .W(WORD_W)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .flush     (rst_req),
        .push      (wr_data && start),
        .din       (bus_wdata[WORD_W-1:0]),
        .full      (full),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_word  (out_word),
        .level     (level)
    );

    pr_sticky_errors #(.N(ERR_N)) u_err (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (err_set),
        .clr_en   (wr_err),
        .clr_mask (bus_wdata[ERR_N-1:0]),
        .flags    (err_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_re) begin
            case (sel)
                SEL_CTRL: bus_rdata <= pack_ctrl(rst_req, rst_ack, region_sel, start, done);
                SEL_STAT: bus_rdata <= pack_stat(credits, start, ctl_status_in, host_status_in);
                SEL_ERR:  bus_rdata <= DATA_W'(err_flags);
                SEL_IDH:  bus_rdata <= IFC_ID[127:64];
                SEL_IDL:  bus_rdata <= IFC_ID[63:0];
                default:  bus_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/pr_engine_regs_chk.sv
module pr_engine_regs_chk #(
    parameter int DEPTH = 256
) (
    input logic        clk,
    input logic        rst,
    input logic        rst_req,
    input logic        start,
    input logic        done,
    input logic        wr_data,
    input logic        full,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_word,
    input logic [4:0]  err_flags,
    input logic [8:0]  credits
);

    AST_FLUSH_ON_REQ: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !out_valid); // R2
    AST_REQ_IDLES: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !start && !done); // R2
    AST_CREDIT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        credits <= 9'(DEPTH)); // R5
    AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready && !rst_req |=> out_valid && $stable(out_word)); // R6
    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        start && done && !out_valid |=> !start && !done); // R7
    AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        done |-> start); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        wr_data && start && full |=> err_flags[4]); // R8
    AST_PROTO_FLAG: assert property (@(posedge clk) disable iff (rst)
        wr_data && !start |=> err_flags[3]); // R9

endmodule

bind pr_engine_regs pr_engine_regs_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rst_req   (rst_req),
    .start     (start),
    .done      (done),
    .wr_data   (wr_data),
    .full      (full),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word),
    .err_flags (err_flags),
    .credits   (credits)
);

// File: tb/test_pr_engine_regs.sv
module test_pr_engine_regs;

    localparam int           DEPTH = 256;
    localparam logic [127:0] TB_ID = 128'hA5A5_0F0F_1234_5678_9ABC_DEF0_0102_0304;
    localparam logic [7:0]   A_CTRL = 8'h08, A_STAT = 8'h10, A_DATA = 8'h18,
                             A_ERR = 8'h20, A_IDH = 8'hA8, A_IDL = 8'hB0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [63:0] bus_rdata;
    logic        out_valid, out_ready = 1'b0;
    logic [31:0] out_word;
    logic        ev_op_err = 1'b0, ev_crc_err = 1'b0, ev_bad_image = 1'b0;
    logic [2:0]  ctl_status_in = 3'b101;
    logic [3:0]  host_status_in = 4'hA;
    logic [2:0]  region_sel;

    int total = 0, bad = 0;
    bit finished = 0;
    logic [31:0] exp_q[$];

    always #5 clk = ~clk;

    pr_engine_regs #(.DEPTH(DEPTH), .IFC_ID(TB_ID)) i_pr_engine_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
        .ev_op_err(ev_op_err), .ev_crc_err(ev_crc_err), .ev_bad_image(ev_bad_image),
        .ctl_status_in(ctl_status_in), .host_status_in(host_status_in),
        .region_sel(region_sel)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_ctrl(input logic req, input logic ack,
        input logic [2:0] rg, input logic st, input logic dn);
        return {50'd0, dn, st, 2'b00, rg, 2'b00, ack, 3'b000, req};
    endfunction

    function automatic logic [63:0] mk_stat(input int cr, input logic busy,
        input logic [2:0] c, input logic [3:0] h);
        return {36'd0, h, 1'b0, c, 3'b000, busy, 7'd0, 9'(cr)};
    endfunction

    task automatic bus_wr(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [63:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    // driver: every word expected to be accepted goes to the scoreboard
    task automatic push_word(input logic [31:0] w, input bit accept);
        bus_wr(A_DATA, {32'hBAD0_0000 ^ {w[15:0], w[31:16]}, w});
        if (accept) exp_q.push_back(w);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pop and compare on each handshake
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (!rst && out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk("R6 unexpected word", {32'd0, out_word}, 64'hFFFF_FFFF_FFFF_FFFF);
                end else begin
                    chk("R6 stream order", {32'd0, out_word}, {32'd0, exp_q.pop_front()});
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] rd;
        logic [2:0]  rg;
        rg = 3'd5;
        idle(4);
        @(negedge clk) rst = 1'b0;

        // reset state and identifier
        bus_rd(A_CTRL, rd); chk("R2 reset control", rd, 64'd0);
        bus_rd(A_STAT, rd); chk("R5 reset status", rd, mk_stat(DEPTH, 0, 3'b101, 4'hA));
        bus_rd(A_ERR, rd);  chk("R10 reset errors", rd, 64'd0);
        bus_rd(A_IDH, rd);  chk("R1 id upper", rd, TB_ID[127:64]);
        bus_rd(A_IDL, rd);  chk("R1 id lower", rd, TB_ID[63:0]);
        bus_rd(8'h00, rd);  chk("R1 unmapped zero", rd, 64'd0);
        bus_rd(A_DATA, rd); chk("R1 data reads zero", rd, 64'd0);
        idle(2);            chk("R1 read data held", bus_rdata, 64'd0);
        chk("R6 idle stream", {63'd0, out_valid}, 64'd0);

        // reset handshake and region
        bus_wr(A_CTRL, 64'h1 | (64'(rg) << 7));
        bus_rd(A_CTRL, rd); chk("R2 ack while held", rd, mk_ctrl(1, 1, rg, 0, 0));
        chk("R3 region_sel", {61'd0, region_sel}, {61'd0, rg});
        bus_wr(A_CTRL, 64'(rg) << 7);
        bus_rd(A_CTRL, rd); chk("R2 ack removed", rd, mk_ctrl(0, 0, rg, 0, 0));
        bus_rd(A_STAT, rd); chk("R2 idle after release", rd, mk_stat(DEPTH, 0, 3'b101, 4'hA));

        // protocol violation
        push_word(32'h1111_2222, 0);
        bus_rd(A_ERR, rd);  chk("R9 protocol flag", rd, 64'h08);
        chk("R9 word dropped", {63'd0, out_valid}, 64'd0);
        bus_rd(A_STAT, rd); chk("R9 credits kept", rd, mk_stat(DEPTH, 0, 3'b101, 4'hA));

        // external pulses and write-one-to-clear
        @(negedge clk); ev_op_err = 1; ev_crc_err = 1; ev_bad_image = 1;
        @(negedge clk); ev_op_err = 0; ev_crc_err = 0; ev_bad_image = 0;
        bus_rd(A_ERR, rd);  chk("R11 event flags", rd, 64'h0F);
        bus_wr(A_ERR, 64'h06);
        bus_rd(A_ERR, rd);  chk("R10 partial clear", rd, 64'h09);
        @(negedge clk); bus_addr = A_ERR; bus_wdata = 64'h02; bus_we = 1; ev_crc_err = 1;
        @(negedge clk); bus_we = 0; ev_crc_err = 0;
        bus_rd(A_ERR, rd);  chk("R10 set beats clear", rd, 64'h0B);
        bus_wr(A_ERR, 64'h1F);
        bus_rd(A_ERR, rd);  chk("R10 full clear", rd, 64'h00);

        // start and busy
        bus_wr(A_CTRL, 64'h1000 | (64'(rg) << 7));
        bus_rd(A_STAT, rd); chk("R4 busy after start", rd, mk_stat(DEPTH, 1, 3'b101, 4'hA));
        bus_wr(A_CTRL, 64'(rg) << 7);
        bus_rd(A_CTRL, rd); chk("R7 start not cleared by zero", rd, mk_ctrl(0, 0, rg, 1, 0));

        // queued words and credits
        push_word(32'hCAFE_0001, 1);
        push_word(32'hCAFE_0002, 1);
        push_word(32'h0000_0003, 1);
        bus_rd(A_STAT, rd); chk("R5 credits consumed", rd, mk_stat(DEPTH - 3, 1, 3'b101, 4'hA));
        chk("R6 valid while stalled", {63'd0, out_valid}, 64'd1);
        chk("R6 head word", {32'd0, out_word}, 64'hCAFE_0001);
        @(negedge clk) out_ready = 1;
        idle(6);
        bus_rd(A_STAT, rd); chk("R6 credits returned", rd, mk_stat(DEPTH, 1, 3'b101, 4'hA));
        chk("R6 scoreboard drained", 64'(exp_q.size()), 64'd0);

        // completion with words pending
        @(negedge clk) out_ready = 0;
        push_word(32'h5555_AAAA, 1);
        push_word(32'h7777_8888, 1);
        bus_wr(A_CTRL, 64'h3000 | (64'(rg) << 7));
        bus_rd(A_CTRL, rd); chk("R7 held until drained", rd, mk_ctrl(0, 0, rg, 1, 1));
        @(negedge clk) out_ready = 1;
        idle(5);
        bus_rd(A_CTRL, rd); chk("R7 self clear", rd, mk_ctrl(0, 0, rg, 0, 0));
        bus_rd(A_STAT, rd); chk("R4 idle after session", rd, mk_stat(DEPTH, 0, 3'b101, 4'hA));
        bus_wr(A_CTRL, 64'h2000 | (64'(rg) << 7));
        bus_rd(A_CTRL, rd); chk("R7 complete needs start", rd, mk_ctrl(0, 0, rg, 0, 0));

        // fill to no credit, then overflow
        @(negedge clk) out_ready = 0;
        bus_wr(A_CTRL, 64'h1000 | (64'(rg) << 7));
        for (int i = 0; i < DEPTH; i++) push_word(32'h9000_0000 + 32'(i * 7), 1);
        bus_rd(A_STAT, rd); chk("R5 no credit left", rd, mk_stat(0, 1, 3'b101, 4'hA));
        bus_rd(A_ERR, rd);  chk("R8 no overflow yet", rd, 64'h00);
        push_word(32'hDEAD_BEEF, 0);
        bus_rd(A_ERR, rd);  chk("R8 overflow flag", rd, 64'h10);
        bus_rd(A_STAT, rd); chk("R8 credits unchanged", rd, mk_stat(0, 1, 3'b101, 4'hA));
        @(negedge clk) out_ready = 1;
        idle(DEPTH + 10);
        chk("R8 dropped word absent", 64'(exp_q.size()), 64'd0);
        bus_wr(A_ERR, 64'h10);
        bus_wr(A_CTRL, 64'h3000 | (64'(rg) << 7));
        idle(3);
        bus_rd(A_STAT, rd); chk("R7 session closed", rd, mk_stat(DEPTH, 0, 3'b101, 4'hA));

        // status pass-through
        @(negedge clk); ctl_status_in = 3'b010; host_status_in = 4'h5;
        bus_rd(A_STAT, rd); chk("R12 status fields", rd, mk_stat(DEPTH, 0, 3'b010, 4'h5));

        // reset request flushes a live session
        @(negedge clk) out_ready = 0;
        bus_wr(A_CTRL, 64'h1000 | (64'(rg) << 7));
        push_word(32'h0BAD_0001, 1);
        push_word(32'h0BAD_0002, 1);
        bus_wr(A_CTRL, 64'h1);
        exp_q.delete();
        bus_rd(A_STAT, rd); chk("R2 flush credits", rd, mk_stat(DEPTH, 0, 3'b010, 4'h5));
        chk("R2 flush stream", {63'd0, out_valid}, 64'd0);
        bus_rd(A_CTRL, rd); chk("R2 flush control", rd, mk_ctrl(1, 1, 3'd0, 0, 0));
        bus_wr(A_CTRL, 64'd0);
        @(negedge clk) out_ready = 1;
        idle(4);
        chk("R6 final scoreboard", 64'(exp_q.size()), 64'd0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule